// File: doc/BRIEF.md
# Tightly Coupled Memory Region Decoder

This block decides, for every address issued on the instruction side and on the data side of a processor, whether the address falls inside that side's tightly coupled memory region. When it does, the block also reports which bank inside the region is being addressed. Each side has its own region register. The register holds a 4 KB-aligned base, a 4-bit size code and an enable bit. Software writes and reads these registers through a small synchronous register port. The same port also exposes a read-only presence word that tells which of the two regions is currently live.

The size code is not linear. Code 0 means the region is absent. Codes 3 to 11 select 4 KB up to 1 MB, doubling at each step. All other codes are reserved and disable the region. Inside an enabled region, the low 64 KB of the region offset is split into four bank classes: two 16 KB RAM banks, an 8 KB ROM, and a reserved range. Offsets at or above 64 KB count as reserved as well. A hit on the reserved class raises an error flag, and the data returned on that side is forced to zero. The memory arrays themselves sit outside this block. The block only gates their read data back to the requester.

Decoding is combinational from the request address to the hit, bank, error and data outputs. A register write takes effect on the clock edge that samples it.

Top module: `tcm_region_decoder`

## Requirements
- R1: Register address 1 holds the instruction region and address 2 the data region. Writes store the base in bits 31:12, the size code in bits 5:2 and the enable in bit 0. Bits 11:6 and bit 1 always read back as zero. A written value is visible from the next clock edge.
- R2: Size codes 0, 1, 2 and 12 to 15 force a miss on that side whatever the enable bit holds.
- R3: With a valid size code c (3 to 11), the region spans 2^(c+9) bytes. A side hits when its enable is 1 and the address divided by the region size equals the base divided by the region size.
- R4: On a hit, the bank output is 0 (RAM0) for region offsets 0x0000–0x3FFF, 1 (RAM1) for 0x4000–0x7FFF, 2 (ROM) for 0x8000–0x9FFF, and 3 (reserved) for 0xA000–0xFFFF and for any offset of 0x10000 or more. On a miss the bank output is 0.
- R5: The error flag is 1 exactly when a side hits bank 3. That side's read data equals its memory data on a non-reserved hit and is zero otherwise.
- R6: Register address 0 reads the presence word. Bit 0 is 1 when the instruction region is enabled with a valid size code, and bit 16 is the same for the data region. Every other bit is 0. Writes to addresses 0 and 3 change nothing, and address 3 reads zero.
- R7: The instruction request is decoded only against the instruction region, and the data request only against the data region, even when both regions cover the same address.
- R8: After reset, the instruction region reads 0x00000018 and the data region reads 0x00010018 (32 KB each, disabled), and neither side hits.
- R9: Writing 0x00010019 to the data region enables 32 KB at 0x00010000. In that region, 0x00017FFC hits RAM1 and 0x00018000 misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register index (0 presence, 1 instruction, 2 data) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| iAddr | input | 32 | Instruction-side request address |
| iMemData | input | DATA_W | Instruction-side memory read data |
| iHit | output | 1 | Instruction region hit |
| iBank | output | 2 | Instruction-side bank class |
| iErr | output | 1 | Instruction-side reserved-bank hit |
| iRdData | output | DATA_W | Gated instruction-side read data |
| dAddr | input | 32 | Data-side request address |
| dMemData | input | DATA_W | Data-side memory read data |
| dHit | output | 1 | Data region hit |
| dBank | output | 2 | Data-side bank class |
| dErr | output | 1 | Data-side reserved-bank hit |
| dRdData | output | DATA_W | Gated data-side read data |

## Verification
The hardest cases to reach are the reserved bank class and the offsets past 64 KB. Both exist only when the region is 64 KB or larger, so a bench that keeps the reset sizes never sees them. The stimulus therefore walks every one of the 16 size codes, with both enable values, and for each one steps an address across the region from below its base to past 1 MB. On each step it compares both sides against a division-and-remainder model. The two regions get different bases, and each side is also driven with the other side's address, so any cross-side decoding shows up as a false hit.

// File: rtl/tcmdec_pkg.sv
package tcmdec_pkg;
  localparam int REG_W      = 32;
  localparam int ADDR_W     = 32;
  localparam int BASE_LSB   = 12;
  localparam int WIN_BITS   = 16;
  localparam int STAT_I_BIT = 0;
  localparam int STAT_D_BIT = 16;
  localparam logic [REG_W-1:0] WR_KEEP_MASK = 32'hFFFF_F03D;

  localparam logic [1:0] REG_STATUS  = 2'd0;
  localparam logic [1:0] REG_IREGION = 2'd1;
  localparam logic [1:0] REG_DREGION = 2'd2;

  typedef enum logic [1:0] {
    BANK_RAM0 = 2'd0,
    BANK_RAM1 = 2'd1,
    BANK_ROM  = 2'd2,
    BANK_RSVD = 2'd3
  } bank_e;

  typedef struct packed {
    logic       wrIRegion;
    logic       wrDRegion;
    logic [1:0] rdSel;
  } regStrobes_t;

  function automatic logic sizeCodeValid(input logic [3:0] code);
    return (code >= 4'd3) && (code <= 4'd11);
  endfunction

  function automatic logic [4:0] sizeLog2(input logic [3:0] code);
    return {1'b0, code} + 5'd9;
  endfunction
endpackage

// File: rtl/tcmdec_ctrl.sv
module tcmdec_ctrl
  import tcmdec_pkg::*;
(
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  output regStrobes_t strobes
);
  always_comb begin
    strobes.wrIRegion = regWrEn && (regAddr == REG_IREGION);
    strobes.wrDRegion = regWrEn && (regAddr == REG_DREGION);
    strobes.rdSel     = regAddr;
  end
endmodule

// File: rtl/tcmdec_datapath.sv
module tcmdec_datapath
  import tcmdec_pkg::*;
#(
  parameter int               DATA_W  = 32,
  parameter logic [REG_W-1:0] I_RESET = 32'h0000_0018,
  parameter logic [REG_W-1:0] D_RESET = 32'h0001_0018
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  regStrobes_t                  strobes,
  input  logic [REG_W-1:0]             regWrData,
  output logic [REG_W-1:0]             regRdData,
  input  logic [1:0][ADDR_W-1:0]       reqAddr,
  input  logic [1:0][DATA_W-1:0]       memData,
  output logic [1:0]                   hitO,
  output logic [1:0][1:0]              bankO,
  output logic [1:0]                   errO,
  output logic [1:0][DATA_W-1:0]       rdDataO
);
  localparam int NSIDE = 2;

  logic [NSIDE-1:0][REG_W-1:0] regionQ;
  logic [NSIDE-1:0]            wrVec;
  logic [NSIDE-1:0]            present;

  assign wrVec = {strobes.wrDRegion, strobes.wrIRegion};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regionQ[0] <= I_RESET;
      regionQ[1] <= D_RESET;
    end else begin
      for (int s = 0; s < NSIDE; s++)
        if (wrVec[s]) regionQ[s] <= regWrData & WR_KEEP_MASK;
    end
  end

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    logic [3:0]        sizeCode;
    logic [ADDR_W-1:0] upperMask;
    logic [ADDR_W-1:0] offset;
    bank_e             bankRaw;

    assign sizeCode   = regionQ[s][5:2];
    assign present[s] = regionQ[s][0] && sizeCodeValid(sizeCode);
    assign upperMask  = {ADDR_W{1'b1}} << sizeLog2(sizeCode);
    assign offset     = reqAddr[s] & ~upperMask;

    always_comb begin
      if (|offset[ADDR_W-1:WIN_BITS]) bankRaw = BANK_RSVD;
      else begin
        unique case (offset[WIN_BITS-1:13])
          3'd0, 3'd1: bankRaw = BANK_RAM0;
          3'd2, 3'd3: bankRaw = BANK_RAM1;
          3'd4:       bankRaw = BANK_ROM;
          default:    bankRaw = BANK_RSVD;
        endcase
      end
    end

    assign hitO[s]    = present[s] && ((reqAddr[s] & upperMask) == (regionQ[s] & upperMask));
    assign bankO[s]   = hitO[s] ? bankRaw : BANK_RAM0;
    assign errO[s]    = hitO[s] && (bankRaw == BANK_RSVD);
    assign rdDataO[s] = (hitO[s] && !errO[s]) ? memData[s] : '0;

    // R1
    reg_write_chk: assert property (@(posedge clk) disable iff (!rstN)
      wrVec[s] |=> (regionQ[s][31:BASE_LSB] == $past(regWrData[31:BASE_LSB]))
                   && (regionQ[s][11:6] == 6'd0) && !regionQ[s][1]);
    // R1
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !wrVec[s] |=> $stable(regionQ[s]));
    // R2
    rsvd_code_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
      !sizeCodeValid(regionQ[s][5:2]) |-> !hitO[s]);
    // R5
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
      errO[s] |-> (rdDataO[s] == '0) && (bankO[s] == 2'd3));
    // R5
    miss_zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
      !hitO[s] |-> (rdDataO[s] == '0) && !errO[s]);
  end

  always_comb begin
    regRdData = '0;
    unique case (strobes.rdSel)
      REG_STATUS: begin
        regRdData[STAT_I_BIT] = present[0];
        regRdData[STAT_D_BIT] = present[1];
      end
      REG_IREGION: regRdData = regionQ[0];
      REG_DREGION: regRdData = regionQ[1];
      default:     regRdData = '0;
    endcase
  end

  // R6
  status_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdSel == REG_STATUS) |->
      ((regRdData & ~((32'd1 << STAT_D_BIT) | (32'd1 << STAT_I_BIT))) == '0));
endmodule

// File: rtl/tcm_region_decoder.sv
module tcm_region_decoder
  import tcmdec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [31:0]       iAddr,
  input  logic [DATA_W-1:0] iMemData,
  output logic              iHit,
  output logic [1:0]        iBank,
  output logic              iErr,
  output logic [DATA_W-1:0] iRdData,
  input  logic [31:0]       dAddr,
  input  logic [DATA_W-1:0] dMemData,
  output logic              dHit,
  output logic [1:0]        dBank,
  output logic              dErr,
  output logic [DATA_W-1:0] dRdData
);
  regStrobes_t           strobes;
  logic [1:0]            hitV;
  logic [1:0]            errV;
  logic [1:0][1:0]       bankV;
  logic [1:0][DATA_W-1:0] rdV;

  tcmdec_ctrl ctrl_i (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  tcmdec_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .reqAddr   ({dAddr, iAddr}),
    .memData   ({dMemData, iMemData}),
    .hitO      (hitV),
    .bankO     (bankV),
    .errO      (errV),
    .rdDataO   (rdV)
  );

  assign iHit    = hitV[0];
  assign iBank   = bankV[0];
  assign iErr    = errV[0];
  assign iRdData = rdV[0];
  assign dHit    = hitV[1];
  assign dBank   = bankV[1];
  assign dErr    = errV[1];
  assign dRdData = rdV[1];
endmodule

// File: tb/tcm_region_decoder_tb.sv
`timescale 1ns/1ps
module tcm_region_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [1:0]  regAddr;
  logic [31:0] regWrData, regRdData;
  logic [31:0] iAddr, iMemData, iRdData, dAddr, dMemData, dRdData;
  logic        iHit, iErr, dHit, dErr;
  logic [1:0]  iBank, dBank;

  int checks = 0;
  int errors = 0;
  logic [31:0] iModel, dModel;

  always #2 clk = ~clk;

  tcm_region_decoder dut_i (.*);

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected under 150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] rv, input logic [31:0] a,
                                output logic hit, output logic [1:0] bank);
    logic [3:0] code;
    longint unsigned size, off;
    code = rv[5:2];
    hit = 1'b0; bank = 2'd0;
    if (rv[0] && code >= 3 && code <= 11) begin
      size = 64'd1 << (code + 9);
      hit  = (longint'(a) / size) == (longint'({rv[31:12], 12'h000}) / size);
      off  = longint'(a) % size;
      if (hit) begin
        if (off >= 65536)      bank = 2'd3;
        else if (off < 16384)  bank = 2'd0;
        else if (off < 32768)  bank = 2'd1;
        else if (off < 40960)  bank = 2'd2;
        else                   bank = 2'd3;
      end
    end
  endfunction

  task automatic regWrite(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a == 2'd1) iModel = v & 32'hFFFF_F03D;
    if (a == 2'd2) dModel = v & 32'hFFFF_F03D;
  endtask

  task automatic regRead(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #1 chk(tag, regRdData, exp);
  endtask

  function automatic logic [31:0] statusExp();
    logic [31:0] s;
    s = 32'd0;
    s[0]  = iModel[0] && iModel[5:2] >= 3 && iModel[5:2] <= 11;
    s[16] = dModel[0] && dModel[5:2] >= 3 && dModel[5:2] <= 11;
    return s;
  endfunction

  task automatic probe(input logic [31:0] ia, input logic [31:0] da);
    logic eh, er; logic [1:0] eb; string tg;
    @(negedge clk);
    iAddr = ia; dAddr = da;
    iMemData = 32'hA5A5_0000 ^ ia; dMemData = 32'h5A5A_0000 ^ da;
    #1;
    model(iModel, ia, eh, eb);
    er = eh && eb == 2'd3;
    tg = (iModel[5:2] < 3 || iModel[5:2] > 11) ? "R2 i hit" : "R3/R7 i hit";
    chk(tg, iHit, eh);
    chk("R4 i bank", iBank, eb);
    chk("R5 i err", iErr, er);
    chk("R5 i data", iRdData, (eh && !er) ? iMemData : 32'd0);
    model(dModel, da, eh, eb);
    er = eh && eb == 2'd3;
    tg = (dModel[5:2] < 3 || dModel[5:2] > 11) ? "R2 d hit" : "R3/R7 d hit";
    chk(tg, dHit, eh);
    chk("R4 d bank", dBank, eb);
    chk("R5 d err", dErr, er);
    chk("R5 d data", dRdData, (eh && !er) ? dMemData : 32'd0);
  endtask

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regAddr = 2'd0; regWrData = 32'd0;
    iAddr = 32'd0; dAddr = 32'h0001_0000; iMemData = 32'd1; dMemData = 32'd2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    iModel = 32'h0000_0018; dModel = 32'h0001_0018;

    // R8 reset state
    regRead(2'd1, 32'h0000_0018, "R8 i region reset");
    regRead(2'd2, 32'h0001_0018, "R8 d region reset");
    regRead(2'd0, 32'd0, "R8 status reset");
    #1 chk("R8 i miss after reset", iHit, 1'b0);
    chk("R8 d miss after reset", dHit, 1'b0);

    // R1 field masking
    regWrite(2'd1, 32'hFFFF_FFFF);
    regRead(2'd1, 32'hFFFF_F03D, "R1 reserved bits read zero");

    // R6 ignored writes
    regWrite(2'd0, 32'hFFFF_FFFF);
    regWrite(2'd3, 32'hFFFF_FFFF);
    regRead(2'd3, 32'd0, "R6 address 3 reads zero");
    regRead(2'd2, 32'h0001_0018, "R6 write to 0/3 left data region");
    regRead(2'd1, 32'hFFFF_F03D, "R6 write to 0/3 left instr region");

    // R9 worked example
    regWrite(2'd2, 32'h0001_0019);
    regWrite(2'd1, 32'h0000_0019);
    regRead(2'd2, 32'h0001_0019, "R9 readback");
    regRead(2'd0, 32'h0001_0001, "R6 both present");
    probe(32'h0000_7FFC, 32'h0001_7FFC);
    chk("R9 0x17FFC hit", dHit, 1'b1);
    chk("R9 0x17FFC RAM1", dBank, 2'd1);
    probe(32'h0000_8000, 32'h0001_8000);
    chk("R9 0x18000 miss", dHit, 1'b0);
    probe(32'h0001_0000, 32'h0000_0000);
    chk("R7 i ignores data region", iHit, 1'b0);
    chk("R7 d ignores instr region", dHit, 1'b0);

    // R2/R3/R4/R5/R7 sweep over every size code and enable value
    for (int code = 0; code < 16; code++) begin
      for (int en = 0; en < 2; en++) begin
        regWrite(2'd2, 32'h0012_0000 | (code << 2) | en | 32'h0000_0FC2);
        regWrite(2'd1, 32'h0090_0000 | (code << 2) | en);
        regRead(2'd0, statusExp(), "R6 status during sweep");
        for (int k = 0; k < 106; k++) begin
          logic [31:0] off;
          off = k * 32'h2C00 - 32'h3000;
          probe(32'h0090_0000 + off, 32'h0012_0000 + off);
          probe(32'h0012_0000 + off, 32'h0090_0000 + off);
        end
      end
    end

    // R6 reserved code with enable is not present
    regWrite(2'd1, 32'h0000_0031);
    regWrite(2'd2, 32'h0001_0005);
    regRead(2'd0, 32'd0, "R6 reserved codes absent");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule